// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block watches four active-low modem handshake inputs (carrier detect, ring indicator, data-set-ready and clear-to-send) and presents them to a processor as one 8-bit status byte. The high nibble gives the present level of each line, inverted so that an asserted line reads as 1. The low nibble holds one sticky change flag per line. Reading the byte, marked by a one-cycle read strobe, clears all four flags. An interrupt request is high while any flag is set.

Each external input passes through a synchronizer before it is used. The ring indicator flag only reports the end of a ring (its pin going from low to high), while the other three flags report any change. A loopback control replaces the four pins with four bits of the modem control register, so software can drive the whole change and interrupt path without touching the pins. After reset the block waits until its synchronizers and history hold real data before it compares anything, so no change is invented at start-up.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, status bits 7, 6, 5 and 4 read as the inverse of the carrier detect, ring indicator, data-set-ready and clear-to-send pins respectively, visible two clock edges after the pin settles.
- R2: With loopback_en high, status bit 7 equals ctl_bits[3], bit 6 equals ctl_bits[2], bit 5 equals ctl_bits[0] and bit 4 equals ctl_bits[1]; the four pins have no effect on the status byte.
- R3: Flag bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send) set when the level of their line changes in either direction; outside loopback the flag appears three clock edges after the pin changes.
- R4: Flag bit 2 (ring) sets only when status bit 6 goes from 1 to 0, that is when the ring pin goes from low to high; the opposite transition leaves it clear.
- R5: A set flag stays set until a read strobe.
- R6: A clock edge with rd_stb high clears the flags; during that cycle status_q still shows the flags as they were before the read.
- R7: A change detected in the same cycle as a read strobe is kept: its flag is set after the edge while the other flags clear.
- R8: irq is high exactly when at least one of status bits 3 to 0 is 1.
- R9: In loopback, changes of the mapped control bits set the flags by the same rules as R3 and R4, one clock edge after the control bits change.
- R10: A synchronous reset clears all flags and irq, and after reset no flag is set by the levels present at start-up, whatever level the pins or control bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| loopback_en | input | 1 | Selects the control bits instead of the pins |
| ctl_bits | input | 4 | Modem control outputs: [0] terminal ready, [1] request to send, [2] user output 1, [3] user output 2 |
| rd_stb | input | 1 | One-cycle read strobe for the status byte |
| status_q | output | 8 | Line levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem status interrupt request |

## Verification
A pin change reaches the level bits after two clock edges and the flag bits and irq after three, while a control bit change in loopback reaches the level bits at once and the flags after one edge. The bench drives every input on the falling clock edge and then waits four rising edges before sampling, which covers the longest of these paths with margin, and it samples a read value during the strobe cycle itself, before the rising edge that clears the flags. The read-with-change case is checked in the strobe cycle and again one edge later.

// File: rtl/msr_pkg.sv
package msr_pkg;

   localparam int NUM_LINES = 4;

   // Line index inside the level and flag nibbles
   localparam int IDX_CTS = 0;
   localparam int IDX_DSR = 1;
   localparam int IDX_RI  = 2;
   localparam int IDX_CD  = 3;

   // Control register bit positions used in loopback
   localparam int CTL_DTR = 0;
   localparam int CTL_RTS = 1;
   localparam int CTL_OP1 = 2;
   localparam int CTL_OP2 = 3;

   typedef logic [NUM_LINES-1:0] line_vec_t;

   // Ring flag reports only the level falling (pin rising)
   localparam line_vec_t FALL_ONLY_MASK = line_vec_t'(1) << IDX_RI;

   function automatic line_vec_t loop_map(input line_vec_t ctl);
      line_vec_t v;
      v[IDX_CD]  = ctl[CTL_OP2];
      v[IDX_RI]  = ctl[CTL_OP1];
      v[IDX_DSR] = ctl[CTL_DTR];
      v[IDX_CTS] = ctl[CTL_RTS];
      return v;
   endfunction

endpackage

// File: rtl/msr_input_sync.sv
module msr_input_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_input_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("msr_input_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/msr_change_det.sv
module msr_change_det #(
   parameter int           W         = 4,
   parameter logic [W-1:0] FALL_ONLY = '0,
   parameter int           WARMUP    = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] line,
   output logic [W-1:0] det,
   output logic         warm
);

   localparam int CW = $clog2(WARMUP + 1) < 1 ? 1 : $clog2(WARMUP + 1);

   generate
      if (WARMUP < 1) begin : g_bad_warmup
         $error("msr_change_det: WARMUP must be at least 1");
      end
   endgenerate

   logic [CW-1:0] warm_cnt;
   logic [W-1:0]  prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         warm_cnt <= '0;
         prev     <= '0;
      end else begin
         prev <= line;
         if (warm_cnt != CW'(WARMUP)) warm_cnt <= warm_cnt + 1'b1;
      end
   end

   assign warm = (warm_cnt == CW'(WARMUP));

   generate
      for (genvar i = 0; i < W; i++) begin : g_line
         if (FALL_ONLY[i]) begin : g_fall
            assign det[i] = warm & prev[i] & ~line[i];
         end else begin : g_any
            assign det[i] = warm & (prev[i] ^ line[i]);
         end
      end
   endgenerate

endmodule

// File: rtl/msr_flag_bank.sv
module msr_flag_bank #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] det,
   input  logic         rd_stb,
   output logic [W-1:0] flags,
   output logic         irq
);

   always_ff @(posedge clk) begin
      if (rst)         flags <= '0;
      else if (rd_stb) flags <= det;
      else             flags <= flags | det;
   end

   assign irq = |flags;

   // R5: without a read no set flag drops
   assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      !rd_stb |=> (($past(flags) & ~flags) == '0));

   // R6: a read with no new event leaves all flags clear
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && det == '0) |=> (flags == '0));

   // R7: an event coinciding with a read survives the clear
   assert_read_keeps_event_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && det != '0) |=> ((flags & $past(det)) == $past(det)));

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cd_n,
   input  logic       ri_n,
   input  logic       dsr_n,
   input  logic       cts_n,
   input  logic       loopback_en,
   input  logic [3:0] ctl_bits,
   input  logic       rd_stb,
   output logic [7:0] status_q,
   output logic       irq
);
   import msr_pkg::*;

   localparam int WARMUP = SYNC_STAGES + 1;

   line_vec_t pin_raw, pin_sync, line, det, flags;
   logic      warm;

   always_comb begin
      pin_raw          = '1;
      pin_raw[IDX_CD]  = cd_n;
      pin_raw[IDX_RI]  = ri_n;
      pin_raw[IDX_DSR] = dsr_n;
      pin_raw[IDX_CTS] = cts_n;
   end

   msr_input_sync #(
      .W       (NUM_LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('1)
   ) sync_i (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw),
      .q   (pin_sync)
   );

   assign line = loopback_en ? loop_map(ctl_bits) : ~pin_sync;

   msr_change_det #(
      .W         (NUM_LINES),
      .FALL_ONLY (FALL_ONLY_MASK),
      .WARMUP    (WARMUP)
   ) det_i (
      .clk  (clk),
      .rst  (rst),
      .line (line),
      .det  (det),
      .warm (warm)
   );

   msr_flag_bank #(
      .W (NUM_LINES)
   ) flags_i (
      .clk    (clk),
      .rst    (rst),
      .det    (det),
      .rd_stb (rd_stb),
      .flags  (flags),
      .irq    (irq)
   );

   assign status_q = {line, flags};

   // R8: any detected event raises the interrupt on the next edge
   assert_event_raises_irq_R8: assert property (@(posedge clk) disable iff (rst)
      (det != '0) |=> irq);

   // R8: a clean read drops the interrupt
   assert_clean_read_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && det == '0) |=> !irq);

   // R4: the ring level rising never sets the ring flag
   assert_ring_rise_silent_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(status_q[4+IDX_RI]) && !status_q[IDX_RI]) |=> !status_q[IDX_RI]);

   // R9: toggling the terminal-ready control bit in loopback sets the DSR flag
   assert_loop_dsr_flag_R9: assert property (@(posedge clk) disable iff (rst)
      (warm && loopback_en && $past(loopback_en)
       && ctl_bits[CTL_DTR] != $past(ctl_bits[CTL_DTR])) |=> status_q[IDX_DSR]);

   // R10: reset leaves no flag and no interrupt
   assert_reset_clears_R10: assert property (@(posedge clk)
      rst |=> (status_q[3:0] == 4'h0 && !irq));

endmodule

// File: tb/modem_status_reg_tb_top.sv
module modem_status_reg_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 27;

   logic       clk = 1'b0;
   logic       rst;
   logic       cd_n, ri_n, dsr_n, cts_n;
   logic       loopback_en;
   logic [3:0] ctl_bits;
   logic       rd_stb;
   logic [7:0] status_q;
   logic       irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_status_reg dut_i (
      .clk         (clk),
      .rst         (rst),
      .cd_n        (cd_n),
      .ri_n        (ri_n),
      .dsr_n       (dsr_n),
      .cts_n       (cts_n),
      .loopback_en (loopback_en),
      .ctl_bits    (ctl_bits),
      .rd_stb      (rd_stb),
      .status_q    (status_q),
      .irq         (irq)
   );

   // {read, loopback, pins cd/ri/dsr/cts, ctl_bits, expected status}
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 4'b1111, 4'b0000, 8'h00},  // 1 idle, R1
      {1'b0, 1'b0, 4'b1110, 4'b0000, 8'h11},  // 2 CTS asserted, R3
      {1'b1, 1'b0, 4'b1110, 4'b0000, 8'h11},  // 3 read, R6
      {1'b0, 1'b0, 4'b1110, 4'b0000, 8'h10},  // 4 cleared, R6
      {1'b0, 1'b0, 4'b1100, 4'b0000, 8'h32},  // 5 DSR asserted, R3
      {1'b0, 1'b0, 4'b1110, 4'b0000, 8'h12},  // 6 DSR back, sticky R5
      {1'b1, 1'b0, 4'b1110, 4'b0000, 8'h12},  // 7 read
      {1'b0, 1'b0, 4'b1010, 4'b0000, 8'h50},  // 8 ring pin low, no flag R4
      {1'b0, 1'b0, 4'b1110, 4'b0000, 8'h14},  // 9 ring pin high, flag R4
      {1'b1, 1'b0, 4'b1110, 4'b0000, 8'h14},  // 10 read
      {1'b0, 1'b0, 4'b0110, 4'b0000, 8'h98},  // 11 CD asserted, R3
      {1'b1, 1'b0, 4'b0110, 4'b0000, 8'h98},  // 12 read
      {1'b0, 1'b0, 4'b1111, 4'b0000, 8'h09},  // 13 CD and CTS drop, R3
      {1'b1, 1'b0, 4'b1111, 4'b0000, 8'h09},  // 14 read
      {1'b0, 1'b1, 4'b1111, 4'b0000, 8'h00},  // 15 enter loopback, R2
      {1'b0, 1'b1, 4'b1111, 4'b0001, 8'h22},  // 16 DTR -> DSR, R2 R9
      {1'b1, 1'b1, 4'b1111, 4'b0001, 8'h22},  // 17 read
      {1'b0, 1'b1, 4'b1111, 4'b0010, 8'h13},  // 18 RTS -> CTS, R9
      {1'b1, 1'b1, 4'b1111, 4'b0010, 8'h13},  // 19 read
      {1'b0, 1'b1, 4'b1111, 4'b0110, 8'h50},  // 20 OP1 set, ring rises, R4
      {1'b0, 1'b1, 4'b1111, 4'b0010, 8'h14},  // 21 OP1 clear, ring flag R9
      {1'b1, 1'b1, 4'b1111, 4'b0010, 8'h14},  // 22 read
      {1'b0, 1'b1, 4'b1111, 4'b1010, 8'h98},  // 23 OP2 -> CD, R9
      {1'b0, 1'b1, 4'b0000, 4'b1010, 8'h98},  // 24 pins ignored, R2
      {1'b1, 1'b1, 4'b1111, 4'b1010, 8'h98},  // 25 read
      {1'b0, 1'b0, 4'b1111, 4'b0000, 8'h09},  // 26 leave loopback, R3
      {1'b1, 1'b0, 4'b1111, 4'b0000, 8'h09}   // 27 read
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: status actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic drive(input logic lb, input logic [3:0] pins, input logic [3:0] ctl);
      loopback_en = lb;
      {cd_n, ri_n, dsr_n, cts_n} = pins;
      ctl_bits = ctl;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst    = 1'b1;
      rd_stb = 1'b0;
      drive(1'b0, 4'b0000, 4'b0000);   // all lines active during reset
      repeat (3) @(negedge clk);
      #1;
      check8("R10 status in reset", status_q, 8'h00);
      check1("R10 irq in reset", irq, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      check8("R10 no start-up change, R1 levels", status_q, 8'hF0);
      check1("R10 irq after reset", irq, 1'b0);

      // All pins released: CD/DSR/CTS change, ring pin rises
      @(negedge clk);
      drive(1'b0, 4'b1111, 4'b0000);
      repeat (4) @(negedge clk);
      #1;
      check8("R3 R4 all released", status_q, 8'h0F);
      check1("R8 irq with flags", irq, 1'b1);
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      repeat (3) @(negedge clk);

      // Three-edge latency of a pin change (R3)
      drive(1'b0, 4'b1110, 4'b0000);
      repeat (2) @(negedge clk);
      #1;
      check8("R1 level after two edges", status_q, 8'h10);
      @(negedge clk);
      #1;
      check8("R3 flag after three edges", status_q, 8'h11);
      drive(1'b0, 4'b1111, 4'b0000);
      repeat (4) @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      repeat (3) @(negedge clk);

      for (int k = 0; k < NVEC; k++) begin
         logic        is_rd;
         logic        lb;
         logic [3:0]  pins, ctl;
         logic [7:0]  exp;
         {is_rd, lb, pins, ctl, exp} = VEC[k];
         drive(lb, pins, ctl);
         if (is_rd) begin
            rd_stb = 1'b1;
            #1;
            check8($sformatf("R6 vector %0d pre-read value", k + 1), status_q, exp);
            check1($sformatf("R8 vector %0d", k + 1), irq, |exp[3:0]);
            @(negedge clk);
            rd_stb = 1'b0;
            repeat (3) @(negedge clk);
         end else begin
            repeat (4) @(negedge clk);
            #1;
            check8($sformatf("R1-R5 vector %0d", k + 1), status_q, exp);
            check1($sformatf("R8 vector %0d", k + 1), irq, |exp[3:0]);
         end
      end

      // R7: change in the read cycle
      drive(1'b1, 4'b1111, 4'b0010);
      repeat (4) @(negedge clk);
      #1;
      check8("R9 loopback CTS before read", status_q, 8'h11);
      @(negedge clk);
      drive(1'b1, 4'b1111, 4'b0011);
      rd_stb = 1'b1;
      #1;
      check8("R6 pre-read value with new change", status_q, 8'h31);
      @(negedge clk);
      rd_stb = 1'b0;
      #1;
      check8("R7 change kept across read", status_q, 8'h32);
      check1("R7 R8 irq kept", irq, 1'b1);

      // R10: reset in mid-run while loopback holds active levels
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1;
      check8("R10 mid-run reset clears flags", status_q, 8'h30);
      check1("R10 irq cleared", irq, 1'b0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      check8("R10 no spurious change in loopback", status_q, 8'h30);
      check1("R10 irq stays low", irq, 1'b0);

      finish_run();
   end

endmodule